// File: doc/BRIEF.md
# Word Stack Engine over a Byte Memory

This block moves 16-bit words between a requester and a byte-wide memory using last-in, first-out order. A 16-bit stack pointer, held inside the block, gives the offset inside a stack segment. The segment value arrives on an input. Each word becomes two byte accesses in a fixed order around the pointer. The physical byte address is the segment value shifted left by four bits plus the offset.

A push request carries a data word. A pop request carries a destination code. That code is returned unchanged next to the popped word, so the surrounding datapath knows which register to load. A pop whose destination is the code-segment register is refused. While an operation runs the block reports busy. When the operation finishes it raises done for one cycle. The stack pointer can be loaded while the block is idle. It is always visible on an output.

Top module: `word_stack_engine`

## Requirements
- R1: A push accepted in idle writes the high byte of the word at offset SP-1 in the first cycle after acceptance. It writes the low byte at offset SP-2 in the second cycle. mem_we_o is high only in those two cycles.
- R2: When a push completes, the stack pointer is 2 lower, and sp_o shows this in the done cycle. Pushing 24B6H, 85C2H and 5F93H from SP=1236H with segment 0 leaves SP=1230H, byte 93H at address 01230H and byte 24H at 01235H.
- R3: A pop accepted in idle reads the low byte at offset SP in the first cycle after acceptance and the high byte at offset SP+1 in the second. mem_re_o is high only in those two cycles, and mem_we_o stays low.
- R4: When a pop completes, the stack pointer is 2 higher. In the done cycle pop_data_o holds {high byte, low byte} and pop_dst_o holds the request's destination code. Both are held until the next pop completes.
- R5: The physical address is ({ss_i, 4'b0} + offset) modulo 2^20. The offset and the stack pointer both wrap modulo 2^16, so a word can span offsets FFFFH and 0000H of the same segment.
- R6: A pop request with destination code 9 (the code-segment register) is refused. err_o goes high for exactly the next cycle. There is no memory access and no done pulse, and SP is unchanged.
- R7: Each accepted operation keeps busy_o high for three cycles: two byte cycles, then a done cycle in which done_o is high for one cycle. Requests made while busy_o is high are ignored.
- R8: In idle, a stack-pointer load takes priority over any request in the same cycle, and that request is dropped. Otherwise a push takes priority over a simultaneous pop. A load while busy has no effect.
- R9: After reset, SP equals SP_INIT (0 by default). busy_o, done_o, err_o, mem_we_o, mem_re_o, pop_data_o and pop_dst_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ss_i | input | 16 | Stack segment value |
| sp_ld_i | input | 1 | Load the stack pointer (idle only) |
| sp_ld_val_i | input | 16 | Value to load into the stack pointer |
| push_req_i | input | 1 | Push request |
| push_data_i | input | 16 | Word to push |
| pop_req_i | input | 1 | Pop request |
| pop_dst_i | input | 4 | Destination code for the pop |
| sp_o | output | 16 | Current stack pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse when a pop is refused |
| pop_data_o | output | 16 | Last popped word |
| pop_dst_o | output | 4 | Destination code of the last popped word |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 8 | Byte write data |
| mem_we_o | output | 1 | Byte write enable |
| mem_re_o | output | 1 | Byte read strobe |
| mem_rdata_i | input | 8 | Byte read data, valid in the cycle the address is driven |

## Verification
The bench targets the byte order inside a word and the pointer wrap across offset 0000H. A design that swapped the byte order, or that carried the offset into the segment, would write or read the wrong addresses and return a byte-swapped or foreign word. It also refuses a pop to the code segment, which exposes a design that still touched memory, moved SP or pulsed done. Requests made mid-operation and simultaneous load, push and pop requests test the priority rules. A design that restarted or double-stepped would show a stack pointer off by two or more.

// File: rtl/wse_pkg.sv
package wse_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } wse_state_e;

  typedef enum logic {
    OP_POP  = 1'b0,
    OP_PUSH = 1'b1
  } wse_op_e;
endpackage

// File: rtl/wse_sp_reg.sv
module wse_sp_reg #(
  parameter int               PTR_W   = 16,
  parameter logic [PTR_W-1:0] SP_INIT = '0,
  parameter int               STEP    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             step_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] sp_o
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

  logic [PTR_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_INIT;
    else if (ld_i)   sp_q <= ld_val_i;
    else if (step_i) sp_q <= dec_i ? sp_q - STEP_V : sp_q + STEP_V;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/wse_addr_gen.sv
module wse_addr_gen #(
  parameter int PTR_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  ss_i,
  input  logic [PTR_W-1:0]  sp_i,
  input  logic              push_i,
  input  logic              second_i,
  output logic [PHYS_W-1:0] phys_o
);
  localparam logic [PTR_W-1:0] MINUS1 = '1;
  localparam logic [PTR_W-1:0] MINUS2 = MINUS1 - PTR_W'(1);
  localparam logic [PTR_W-1:0] PLUS1  = PTR_W'(1);

  logic [PTR_W-1:0]  delta;
  logic [PTR_W-1:0]  offset;
  logic [PHYS_W-1:0] base;

  // push: SP-1 then SP-2; pop: SP then SP+1
  always_comb begin
    unique case ({push_i, second_i})
      2'b10:   delta = MINUS1;
      2'b11:   delta = MINUS2;
      2'b01:   delta = PLUS1;
      default: delta = '0;
    endcase
  end

  // offset wraps inside the segment before the segment is added
  assign offset = sp_i + delta;

  generate
    if (SEG_SHIFT > 0) begin : g_shift
      assign base = {ss_i, {SEG_SHIFT{1'b0}}};
    end else begin : g_flat
      assign base = ss_i;
    end
  endgenerate

  assign phys_o = base + PHYS_W'(offset);
endmodule

// File: rtl/wse_ctrl.sv
module wse_ctrl
  import wse_pkg::*;
#(
  parameter int             DST_W   = 4,
  parameter logic [DST_W-1:0] CS_CODE = 4'd9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  input  logic [DST_W-1:0] pop_dst_i,
  output wse_state_e       state_o,
  output wse_op_e          op_o,
  output logic             start_o,
  output logic             err_o
);
  wse_state_e state_q, state_d;
  wse_op_e    op_q;
  logic       reject;
  logic       err_q;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    reject  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!ld_i) begin
          if (push_req_i) begin
            state_d = ST_FIRST;
            start_o = 1'b1;
          end else if (pop_req_i) begin
            if (pop_dst_i == CS_CODE) begin
              reject = 1'b1;
            end else begin
              state_d = ST_FIRST;
              start_o = 1'b1;
            end
          end
        end
      end
      ST_FIRST:  state_d = ST_SECOND;
      ST_SECOND: state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_POP;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= reject;
      if (start_o) op_q <= push_req_i ? OP_PUSH : OP_POP;
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;
  assign err_o   = err_q;
endmodule

// File: rtl/word_stack_engine.sv
module word_stack_engine
  import wse_pkg::*;
#(
  parameter int               PTR_W     = 16,
  parameter int               SEG_W     = 16,
  parameter int               SEG_SHIFT = 4,
  parameter int               BYTE_W    = 8,
  parameter int               DST_W     = 4,
  parameter logic [DST_W-1:0] CS_CODE   = 4'd9,
  parameter logic [PTR_W-1:0] SP_INIT   = '0,
  localparam int              WORD_W    = 2 * BYTE_W,
  localparam int              PHYS_W    = SEG_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEG_W-1:0]  ss_i,
  input  logic              sp_ld_i,
  input  logic [PTR_W-1:0]  sp_ld_val_i,
  input  logic              push_req_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_req_i,
  input  logic [DST_W-1:0]  pop_dst_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] pop_data_o,
  output logic [DST_W-1:0]  pop_dst_o,
  output logic [PHYS_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  wse_state_e state;
  wse_op_e    op;
  logic       start;
  logic       idle;
  logic       in_byte;
  logic       second;
  logic       is_push;

  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] lo_q;
  logic [DST_W-1:0]  dst_q;
  logic [WORD_W-1:0] pop_data_q;
  logic [DST_W-1:0]  pop_dst_q;

  assign idle    = (state == ST_IDLE);
  assign second  = (state == ST_SECOND);
  assign in_byte = (state == ST_FIRST) || second;
  assign is_push = (op == OP_PUSH);

  wse_ctrl #(
    .DST_W   (DST_W),
    .CS_CODE (CS_CODE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (sp_ld_i),
    .push_req_i (push_req_i),
    .pop_req_i  (pop_req_i),
    .pop_dst_i  (pop_dst_i),
    .state_o    (state),
    .op_o       (op),
    .start_o    (start),
    .err_o      (err_o)
  );

  wse_sp_reg #(
    .PTR_W   (PTR_W),
    .SP_INIT (SP_INIT),
    .STEP    (WORD_W / BYTE_W)
  ) u_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (sp_ld_i && idle),
    .ld_val_i (sp_ld_val_i),
    .step_i   (second),
    .dec_i    (is_push),
    .sp_o     (sp_o)
  );

  wse_addr_gen #(
    .PTR_W     (PTR_W),
    .SEG_W     (SEG_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_addr (
    .ss_i     (ss_i),
    .sp_i     (sp_o),
    .push_i   (is_push),
    .second_i (second),
    .phys_o   (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q     <= '0;
      lo_q       <= '0;
      dst_q      <= '0;
      pop_data_q <= '0;
      pop_dst_q  <= '0;
    end else begin
      if (start && push_req_i)  word_q <= push_data_i;
      if (start && !push_req_i) dst_q  <= pop_dst_i;
      if (!is_push && state == ST_FIRST) lo_q <= mem_rdata_i;
      if (!is_push && second) begin
        pop_data_q <= {mem_rdata_i, lo_q};
        pop_dst_q  <= dst_q;
      end
    end
  end

  assign mem_we_o    = is_push && in_byte;
  assign mem_re_o    = !is_push && in_byte;
  assign mem_wdata_o = second ? word_q[BYTE_W-1:0] : word_q[WORD_W-1:BYTE_W];
  assign busy_o      = !idle;
  assign done_o      = (state == ST_DONE);
  assign pop_data_o  = pop_data_q;
  assign pop_dst_o   = pop_dst_q;
endmodule

// File: rtl/wse_stack_chk.sv
module wse_stack_chk #(
  parameter int               PTR_W     = 16,
  parameter int               SEG_W     = 16,
  parameter int               SEG_SHIFT = 4,
  parameter int               DST_W     = 4,
  localparam int              PHYS_W    = SEG_W + SEG_SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEG_W-1:0]  ss_i,
  input logic [PTR_W-1:0]  sp_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [PHYS_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o
);
  function automatic logic [PHYS_W-1:0] phys(input logic [SEG_W-1:0] s,
                                             input logic [PTR_W-1:0] o);
    return PHYS_W'({s, {SEG_SHIFT{1'b0}}}) + PHYS_W'(o);
  endfunction

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO = PTR_W'(2);

  AST_PUSH_HIGH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !$past(busy_o)) |-> mem_addr_o == phys(ss_i, sp_o - ONE)); // R1
  AST_PUSH_LOW_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == phys(ss_i, sp_o - TWO)); // R1
  AST_PUSH_SP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_we_o)) |-> sp_o == $past(sp_o) - TWO); // R2
  AST_POP_LOW_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !$past(busy_o)) |-> mem_addr_o == phys(ss_i, sp_o)); // R3
  AST_POP_HIGH_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> mem_addr_o == phys(ss_i, sp_o + ONE)); // R3
  AST_NO_RW_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R3
  AST_POP_SP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_re_o)) |-> sp_o == $past(sp_o) + TWO); // R4
  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !mem_we_o && !mem_re_o && $stable(sp_o))); // R6
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R7
  AST_DONE_AFTER_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(mem_we_o) || $past(mem_re_o))); // R7
endmodule

bind word_stack_engine wse_stack_chk #(
  .PTR_W     (PTR_W),
  .SEG_W     (SEG_W),
  .SEG_SHIFT (SEG_SHIFT),
  .DST_W     (DST_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ss_i       (ss_i),
  .sp_o       (sp_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o)
);

// File: tb/tb_word_stack_engine.sv
`timescale 1ns/1ps
module tb_word_stack_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ss = '0;
  logic        sp_ld = 1'b0;
  logic [15:0] sp_ld_val = '0;
  logic        push_req = 1'b0;
  logic [15:0] push_data = '0;
  logic        pop_req = 1'b0;
  logic [3:0]  pop_dst = '0;
  logic [15:0] sp;
  logic        busy, done, err;
  logic [15:0] pop_data;
  logic [3:0]  pop_dst_out;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  word_stack_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .ss_i(ss), .sp_ld_i(sp_ld), .sp_ld_val_i(sp_ld_val),
    .push_req_i(push_req), .push_data_i(push_data), .pop_req_i(pop_req),
    .pop_dst_i(pop_dst), .sp_o(sp), .busy_o(busy), .done_o(done), .err_o(err),
    .pop_data_o(pop_data), .pop_dst_o(pop_dst_out), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_rdata_i(mem_rdata)
  );

  // bench byte memory driven by the design
  logic [7:0] bmem [int unsigned];
  function automatic logic [7:0] brd(input logic [19:0] a);
    return bmem.exists(a) ? bmem[a] : 8'h00;
  endfunction
  always @(posedge clk) if (rst_n && mem_we) bmem[mem_addr] = mem_wdata;
  always @(negedge clk) mem_rdata <= brd(mem_addr);

  // reference model
  logic [7:0] emem [int unsigned];
  function automatic logic [7:0] erd(input logic [19:0] a);
    return emem.exists(a) ? emem[a] : 8'h00;
  endfunction
  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  int          m_ph;
  bit          m_push;
  logic [15:0] m_sp, m_word, m_pd;
  logic [7:0]  m_lo;
  logic [3:0]  m_dst, m_pdst;
  bit          m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_push = 0; m_sp = 16'h0000; m_word = '0; m_pd = '0;
      m_lo = '0; m_dst = '0; m_pdst = '0; m_err = 0;
    end else begin
      m_err = 0;
      case (m_ph)
        0: begin
          if (sp_ld) m_sp = sp_ld_val;
          else if (push_req) begin m_ph = 1; m_push = 1; m_word = push_data; end
          else if (pop_req) begin
            if (pop_dst == 4'd9) m_err = 1;
            else begin m_ph = 1; m_push = 0; m_dst = pop_dst; end
          end
        end
        1: begin
          if (m_push) emem[phys(ss, m_sp - 16'd1)] = m_word[15:8];
          else m_lo = erd(phys(ss, m_sp));
          m_ph = 2;
        end
        2: begin
          if (m_push) begin
            emem[phys(ss, m_sp - 16'd2)] = m_word[7:0];
            m_sp = m_sp - 16'd2;
          end else begin
            m_pd = {erd(phys(ss, m_sp + 16'd1)), m_lo};
            m_pdst = m_dst;
            m_sp = m_sp + 16'd2;
          end
          m_ph = 3;
        end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic exp_we, exp_re;
      logic [19:0] exp_addr;
      exp_we = m_push && (m_ph == 1 || m_ph == 2);
      exp_re = !m_push && (m_ph == 1 || m_ph == 2);
      exp_addr = m_push ? phys(ss, m_sp - ((m_ph == 1) ? 16'd1 : 16'd2))
                        : phys(ss, m_sp + ((m_ph == 1) ? 16'd0 : 16'd1));
      chk("R7", "busy", busy, m_ph != 0);
      chk("R7", "done", done, m_ph == 3);
      chk("R6", "err", err, m_err);
      chk("R2", "sp", sp, m_sp);
      chk("R1", "mem_we", mem_we, exp_we);
      chk("R3", "mem_re", mem_re, exp_re);
      chk("R4", "pop_data", pop_data, m_pd);
      chk("R4", "pop_dst", pop_dst_out, m_pdst);
      if (exp_we || exp_re) chk("R5", "mem_addr", mem_addr, exp_addr);
      if (exp_we) chk("R1", "mem_wdata", mem_wdata, (m_ph == 1) ? m_word[15:8] : m_word[7:0]);
    end
  end

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk); sp_ld = 1; sp_ld_val = v;
    @(negedge clk); sp_ld = 0;
  endtask

  task automatic push_w(input logic [15:0] w);
    @(negedge clk); push_req = 1; push_data = w;
    @(negedge clk); push_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_w(input logic [3:0] d);
    @(negedge clk); pop_req = 1; pop_dst = d;
    @(negedge clk); pop_req = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset sp", sp, 16'h0000);
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset err", err, 0);
    chk("R9", "reset we/re", {mem_we, mem_re}, 0);
    chk("R9", "reset pop_data", pop_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 worked example
    load_sp(16'h1236);
    push_w(16'h24B6); push_w(16'h85C2); push_w(16'h5F93);
    chk("R2", "sp after three pushes", sp, 16'h1230);
    chk("R2", "byte at 01230", brd(20'h01230), 8'h93);
    chk("R2", "byte at 01235", brd(20'h01235), 8'h24);
    chk("R1", "byte at 01231", brd(20'h01231), 8'h5F);

    // R4 pops return in reverse order
    pop_w(4'd1); chk("R4", "pop 1", pop_data, 16'h5F93); chk("R4", "dst 1", pop_dst_out, 4'd1);
    pop_w(4'd2); chk("R4", "pop 2", pop_data, 16'h85C2);
    pop_w(4'd3); chk("R4", "pop 3", pop_data, 16'h24B6);
    chk("R4", "sp restored", sp, 16'h1236);

    // R5 wrap inside the segment
    ss = 16'h1000;
    load_sp(16'h0001);
    push_w(16'h1234);
    chk("R5", "high byte at offset 0000", brd(20'h10000), 8'h12);
    chk("R5", "low byte at offset FFFF", brd(20'h1FFFF), 8'h34);
    chk("R5", "sp wrapped", sp, 16'hFFFF);
    pop_w(4'd5);
    chk("R5", "pop across wrap", pop_data, 16'h1234);
    chk("R5", "sp back", sp, 16'h0001);

    // R6 code-segment pop refused
    load_sp(16'h4000);
    @(negedge clk); pop_req = 1; pop_dst = 4'd9;
    @(negedge clk); pop_req = 0;
    chk("R6", "err pulse", err, 1);
    chk("R6", "no busy", busy, 0);
    chk("R6", "sp kept", sp, 16'h4000);
    @(negedge clk);
    chk("R6", "err cleared", err, 0);
    chk("R6", "pop_data kept", pop_data, 16'h1234);

    // R7 request while busy ignored
    @(negedge clk); push_req = 1; push_data = 16'hBEEF;
    @(negedge clk); push_req = 0; pop_req = 1; pop_dst = 4'd2;
    @(negedge clk); pop_req = 0; sp_ld = 1; sp_ld_val = 16'h7777;
    @(negedge clk); sp_ld = 0;
    repeat (2) @(negedge clk);
    chk("R7", "single step only", sp, 16'h3FFE);
    chk("R7", "idle after", busy, 0);

    // R8 push wins over pop, load wins over push
    @(negedge clk); push_req = 1; pop_req = 1; push_data = 16'hA55A; pop_dst = 4'd4;
    @(negedge clk); push_req = 0; pop_req = 0;
    repeat (3) @(negedge clk);
    chk("R8", "push chosen", sp, 16'h3FFC);
    chk("R8", "pushed byte", brd(phys(16'h1000, 16'h3FFD)), 8'hA5);
    @(negedge clk); sp_ld = 1; sp_ld_val = 16'h2222; push_req = 1; push_data = 16'h0101;
    @(negedge clk); sp_ld = 0; push_req = 0;
    chk("R8", "load taken", sp, 16'h2222);
    chk("R8", "push dropped", busy, 0);
    repeat (4) @(negedge clk);
    chk("R8", "still loaded", sp, 16'h2222);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule